// File: doc/BRIEF.md
# Multi-Channel PWM Controller with Shadowed Duty Registers

This block drives a parameterised number of pulse-width-modulated outputs from one shared time base. A prescaler divides the clock, and a period counter counts from zero up to a programmable period value and then returns to zero. The return to zero is the period boundary. Each channel holds two edge positions. The output goes high at the rising position and low at the falling position. If the falling position is below the rising one, the pulse wraps across the period boundary.

A build-time mask selects which channels get buffer copies of their two edge registers. A run-time control bit chooses when those channels take new values. In synchronous mode, buffered values move into the active registers together at the next period boundary. In immediate mode, writes take effect at once. Channels without buffers always update at once. A second build-time mask turns selected channels into low-ripple pulse-density converters. Such a channel adds its rising-edge value to an accumulator on every clock and outputs the carry. Every channel has a run-time enable and an output inversion, both applied in the last stage.

Software programs the block through a simple write-only bus. A write happens in the cycle where select, enable and write are all high. Register word addresses: 0 prescale, 1 period, 2 control (bit 0 = synchronous mode), 3 channel enable mask, 4 channel inversion mask, 8+2c rising position of channel c, 9+2c falling position of channel c.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset all registers are zero, all channels are disabled and every output is low.
- R2: With prescale value P the period counter advances once every P+1 clocks. When it advances from a value greater than or equal to the period value (address 1), it returns to 0, and that event is the period boundary.
- R3: A PWM channel is high while the counter is at or above the rising position and below the falling position. When the rising position is above the falling position, the pulse wraps across the boundary. When the two positions are equal, the channel stays low.
- R4: A channel without buffer registers applies a write to its edge registers on the next clock, whatever the value of the synchronous-mode bit.
- R5: A buffered channel in synchronous mode (control bit 0 = 1) keeps its active edge values until the next period boundary and then loads the last written values.
- R6: A buffered channel in immediate mode (control bit 0 = 0) applies an edge write on the next clock.
- R7: Setting bit c of the inversion mask (address 4) inverts output c.
- R8: Clearing bit c of the enable mask (address 3) holds output c at its inactive level, which equals inversion bit c.
- R9: A converter channel adds its rising-edge value to a CW-bit accumulator on every clock and outputs the carry. Over 2^CW clocks it is high exactly (rising value) times.
- R10: Outputs are registered: each output reflects the counter, edge values and masks of the previous clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | Write strobe |
| paddr_i | input | AW | Register word address |
| pwdata_i | input | CW | Write data |
| pwm_o | output | NCH | Channel outputs |

## Verification
A bad period counter or a late prescaler tick moves every PWM edge. This shows on the outputs within one period. A buffer that loads at the wrong time, or an active register that updates too early, shifts one channel's edges. The fault appears in the cycle where the counter first passes the affected position. An accumulator fault changes the converter bit stream on the very next clock. The bench compares every output on every clock against a behavioural model, so each of these faults is reported at the first cycle it becomes visible.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADR_PRESC   = 0;
  localparam int ADR_PERIOD  = 1;
  localparam int ADR_CTRL    = 2;
  localparam int ADR_EN      = 3;
  localparam int ADR_POL     = 4;
  localparam int ADR_CH_BASE = 8;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] prescale_i,
  input  logic [CW-1:0] period_i,
  output logic [CW-1:0] cnt_o,
  output logic          start_o
);
  logic [CW-1:0] pre_q, cnt_q;
  logic tick, wrap;

  assign tick    = pre_q >= prescale_i;
  assign wrap    = tick && (cnt_q >= period_i);
  assign cnt_o   = cnt_q;
  assign start_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (wrap)      cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_q >= period_i) |=> (cnt_q == '0));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW     = 8,
  parameter bit SHADOW = 1'b0,
  parameter bit DAC    = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          load_i,
  input  logic          sync_i,
  input  logic          wr_rise_i,
  input  logic          wr_fall_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          en_i,
  input  logic          pol_i,
  output logic          out_o
);
  logic [CW-1:0] rise_act, fall_act;
  logic [CW-1:0] acc_q;
  logic [CW:0]   acc_sum;
  logic          win_lvl, lvl, out_q;
  logic          buffered;

  assign buffered = SHADOW && sync_i;

  generate
    if (SHADOW) begin : g_shadow
      logic [CW-1:0] rise_buf, fall_buf;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          rise_buf <= '0;
          fall_buf <= '0;
          rise_act <= '0;
          fall_act <= '0;
        end else begin
          if (wr_rise_i) rise_buf <= wdata_i;
          if (wr_fall_i) fall_buf <= wdata_i;
          if (sync_i) begin
            if (load_i) begin
              rise_act <= rise_buf;
              fall_act <= fall_buf;
            end
          end else begin
            if (wr_rise_i) rise_act <= wdata_i;
            if (wr_fall_i) fall_act <= wdata_i;
          end
        end
      end
    end else begin : g_direct
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          rise_act <= '0;
          fall_act <= '0;
        end else begin
          if (wr_rise_i) rise_act <= wdata_i;
          if (wr_fall_i) fall_act <= wdata_i;
        end
      end
    end
  endgenerate

  always_comb begin
    if (rise_act < fall_act)      win_lvl = (cnt_i >= rise_act) && (cnt_i < fall_act);
    else if (rise_act > fall_act) win_lvl = (cnt_i >= rise_act) || (cnt_i < fall_act);
    else                          win_lvl = 1'b0;
  end

  assign acc_sum = {1'b0, acc_q} + {1'b0, rise_act};

  generate
    if (DAC) begin : g_dac
      assign lvl = acc_sum[CW];
    end else begin : g_pwm
      assign lvl = win_lvl;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      out_q <= 1'b0;
    end else begin
      acc_q <= acc_sum[CW-1:0];
      out_q <= en_i ? (lvl ^ pol_i) : pol_i;
    end
  end

  assign out_o = out_q;

  assert_sync_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buffered && !load_i) |=> ($stable(rise_act) && $stable(fall_act)));
  assert_direct_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!buffered && wr_rise_i) |=> (rise_act == $past(wdata_i)));
  assert_off_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (out_o == $past(pol_i)));
  assert_equal_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!DAC && en_i && !pol_i && rise_act == fall_act) |=> !out_o);
endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
  import pwm_pkg::*;
#(
  parameter int             NCH         = 4,
  parameter int             CW          = 8,
  parameter int             AW          = 6,
  parameter logic [NCH-1:0] SHADOW_MASK = 4'b0101,
  parameter logic [NCH-1:0] DAC_MASK    = 4'b1000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           psel_i,
  input  logic           penable_i,
  input  logic           pwrite_i,
  input  logic [AW-1:0]  paddr_i,
  input  logic [CW-1:0]  pwdata_i,
  output logic [NCH-1:0] pwm_o
);
  logic [CW-1:0]  prescale_q, period_q, cnt;
  logic [NCH-1:0] en_q, pol_q;
  logic           sync_q, start, wr;

  assign wr = psel_i && penable_i && pwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prescale_q <= '0;
      period_q   <= '0;
      sync_q     <= 1'b0;
      en_q       <= '0;
      pol_q      <= '0;
    end else if (wr) begin
      if (paddr_i == AW'(ADR_PRESC))  prescale_q <= pwdata_i;
      if (paddr_i == AW'(ADR_PERIOD)) period_q   <= pwdata_i;
      if (paddr_i == AW'(ADR_CTRL))   sync_q     <= pwdata_i[0];
      if (paddr_i == AW'(ADR_EN))     en_q       <= pwdata_i[NCH-1:0];
      if (paddr_i == AW'(ADR_POL))    pol_q      <= pwdata_i[NCH-1:0];
    end
  end

  pwm_timebase #(.CW(CW)) u_tb (
    .clk_i, .rst_ni,
    .prescale_i(prescale_q),
    .period_i  (period_q),
    .cnt_o     (cnt),
    .start_o   (start)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] A_RISE = AW'(ADR_CH_BASE + 2*c);
    localparam logic [AW-1:0] A_FALL = AW'(ADR_CH_BASE + 2*c + 1);
    pwm_channel #(.CW(CW), .SHADOW(SHADOW_MASK[c]), .DAC(DAC_MASK[c])) u_ch (
      .clk_i, .rst_ni,
      .cnt_i    (cnt),
      .load_i   (start),
      .sync_i   (sync_q),
      .wr_rise_i(wr && paddr_i == A_RISE),
      .wr_fall_i(wr && paddr_i == A_FALL),
      .wdata_i  (pwdata_i),
      .en_i     (en_q[c]),
      .pol_i    (pol_q[c]),
      .out_o    (pwm_o[c])
    );
  end

  assert_reset_low_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (pwm_o == '0 || rst_ni));
endmodule

// File: tb/pwm_shadow_ctrl_test.sv
module pwm_shadow_ctrl_test;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int AW  = 6;
  localparam logic [NCH-1:0] SHM = 4'b0101;
  localparam logic [NCH-1:0] DCM = 4'b1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, pen = 0, pwr = 0;
  logic [AW-1:0] paddr = '0;
  logic [CW-1:0] pwdata = '0;
  logic [NCH-1:0] pwm;

  always #10 clk = ~clk;

  pwm_shadow_ctrl #(.NCH(NCH), .CW(CW), .AW(AW), .SHADOW_MASK(SHM), .DAC_MASK(DCM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(pen), .pwrite_i(pwr),
    .paddr_i(paddr), .pwdata_i(pwdata), .pwm_o(pwm));

  int total = 0, bad = 0;
  string req = "R1";
  bit done = 0;

  // behavioural model state
  int m_pre, m_cnt, m_presc, m_per, m_sync, m_en, m_pol;
  int m_rb[NCH], m_fb[NCH], m_ra[NCH], m_fa[NCH], m_acc[NCH];
  logic [NCH-1:0] m_exp;

  function automatic bit win(int cnt, int r, int f);
    if (r < f) return (cnt >= r) && (cnt < f);
    if (r > f) return (cnt >= r) || (cnt < f);
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_presc = 0; m_per = 0; m_sync = 0; m_en = 0; m_pol = 0;
      m_exp = '0;
      for (int c = 0; c < NCH; c++) begin
        m_rb[c] = 0; m_fb[c] = 0; m_ra[c] = 0; m_fa[c] = 0; m_acc[c] = 0;
      end
    end else begin
      bit w, tick, wrap;
      int a, d;
      w = psel && pen && pwr; a = paddr; d = pwdata;
      tick = m_pre >= m_presc;
      wrap = tick && (m_cnt >= m_per);
      for (int c = 0; c < NCH; c++) begin
        bit lvl, pol;
        pol = m_pol[c];
        if (DCM[c]) lvl = (m_acc[c] + m_ra[c]) >= (1 << CW);
        else        lvl = win(m_cnt, m_ra[c], m_fa[c]);
        m_exp[c] = m_en[c] ? (lvl ^ pol) : pol;
        m_acc[c] = (m_acc[c] + m_ra[c]) % (1 << CW);
        if (SHM[c] && m_sync != 0) begin
          if (wrap) begin m_ra[c] = m_rb[c]; m_fa[c] = m_fb[c]; end
        end else if (w) begin
          if (a == 8 + 2*c) m_ra[c] = d;
          if (a == 9 + 2*c) m_fa[c] = d;
        end
        if (w && a == 8 + 2*c) m_rb[c] = d;
        if (w && a == 9 + 2*c) m_fb[c] = d;
      end
      m_pre = tick ? 0 : m_pre + 1;
      if (wrap) m_cnt = 0; else if (tick) m_cnt = m_cnt + 1;
      if (w) begin
        case (a)
          0: m_presc = d;
          1: m_per   = d;
          2: m_sync  = d & 1;
          3: m_en    = d & ((1 << NCH) - 1);
          4: m_pol   = d & ((1 << NCH) - 1);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (pwm !== m_exp) begin
        bad++;
        $display("FAIL %s: pwm=%b expected=%b at %0t", req, pwm, m_exp, $time);
      end
    end
  end

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    psel = 1; pwr = 1; paddr = AW'(a); pwdata = CW'(d); pen = 0;
    @(negedge clk);
    pen = 1;
    @(negedge clk);
    psel = 0; pen = 0; pwr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #100000000;
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    total++;
    if (pwm !== '0) begin bad++; $display("FAIL R1: pwm=%b expected=0000", pwm); end
    rst_n = 1;
    idle(4);
    // R1: still low after reset with zero registers
    total++;
    if (pwm !== '0) begin bad++; $display("FAIL R1: pwm=%b expected=0000", pwm); end

    req = "R2";
    wr_reg(0, 1); wr_reg(1, 9); wr_reg(3, 4'b1111);
    req = "R6";
    wr_reg(8, 2); wr_reg(9, 6);
    idle(60);

    req = "R3";
    wr_reg(10, 7); wr_reg(11, 3);   // wrap-around pulse
    wr_reg(12, 4); wr_reg(13, 4);   // equal positions stay low
    idle(60);
    wr_reg(0, 0); wr_reg(1, 15);    // R2: new prescale and period
    idle(50);

    req = "R5";
    wr_reg(2, 1);
    wr_reg(8, 0); wr_reg(9, 5);
    idle(40);
    wr_reg(12, 1); wr_reg(13, 9);
    idle(40);

    req = "R4";
    wr_reg(10, 2); wr_reg(11, 12);
    idle(30);

    req = "R6";
    wr_reg(2, 0);
    wr_reg(8, 3); wr_reg(9, 11);
    idle(30);

    req = "R7";
    wr_reg(4, 4'b0101);
    idle(40);

    req = "R8";
    wr_reg(3, 4'b1010);
    idle(40);
    wr_reg(3, 4'b1111);

    req = "R9";
    wr_reg(14, 64);
    idle(5);
    begin
      int ones = 0;
      for (int i = 0; i < 256; i++) begin
        @(negedge clk);
        ones += pwm[3];
      end
      total++;
      if (ones != 64) begin bad++; $display("FAIL R9: ones=%0d expected=64", ones); end
    end
    wr_reg(14, 0);
    idle(20);
    wr_reg(14, 255);
    idle(40);

    req = "R10";
    wr_reg(1, 3); wr_reg(8, 1); wr_reg(9, 2);
    idle(30);
    finish_run();
  end
endmodule